// File: doc/BRIEF.md
# Wavetable Oscillator with Note Lookup

A single-voice audio oscillator that turns a 7-bit note number into a stream of signed 16-bit samples. Each note number has a phase increment, computed for a fixed sample rate, in a lookup table. A 32-bit phase accumulator adds the current note's increment on every sample-tick strobe. The upper ten phase bits address a sine table held in block RAM. The table contents never change: pitch is set only by the step size of the phase.

The same phase also produces square, sawtooth and triangle outputs, so all four shapes share one pitch path. A waveform select picks the shape for each tick. The block RAM read takes one cycle. The output strobe therefore rises one cycle after the tick, and the sample it carries is taken from the phase held before that tick's update. While note-valid is low, the accumulator is held at zero and the block emits nothing.

Top module: `wavetable_osc`

## Requirements
- R1: While rst_ni is low, and after it is released until the first qualifying tick, valid_o is 0 and sample_o is 0.
- R2: The increment for note n (0..127) is round(440 * 2^((n-69)/12) * 2^32 / 48000), rounded to the nearest integer.
- R3: On each cycle where tick_i and note_valid_i are both 1, the phase advances by the increment of note_i, modulo 2^32. On any other cycle where note_valid_i is 1, the phase is unchanged.
- R4: A cycle with note_valid_i at 0 clears the phase to zero and produces no output strobe. The next note therefore starts from phase 0.
- R5: valid_o is 1 exactly one cycle after a cycle with tick_i and note_valid_i both 1. The sample is computed from the phase value held before that tick's update, using the wave_sel_i value present at the tick. sample_o is 0 whenever valid_o is 0.
- R6: With wave_sel_i = 0 (sine), the sample is round(32767 * sin(2*pi*k/1024)), where k is phase[31:22].
- R7: With wave_sel_i = 1 (square), the sample is +32767 when phase[31] is 0 and -32767 when phase[31] is 1.
- R8: With wave_sel_i = 2 (sawtooth), the sample is phase[31:16] with bit 15 inverted, read as a two's-complement number.
- R9: With wave_sel_i = 3 (triangle), let t be phase[30:15], bitwise inverted when phase[31] is 1. The sample is t with bit 15 inverted, read as a two's-complement number.
- R10: When note_i changes while note_valid_i stays high, the phase stays continuous. The new increment applies from the next tick onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Sample-tick strobe, one cycle per output sample |
| note_i | input | 7 | Note number 0..127 |
| note_valid_i | input | 1 | Note is sounding; low clears the phase |
| wave_sel_i | input | 2 | 0 sine, 1 square, 2 sawtooth, 3 triangle |
| sample_o | output | 16 | Signed output sample |
| valid_o | output | 1 | Output sample strobe |

## Verification
The bench builds the block with its default parameters: a 32-bit phase, a 1024-entry sine table and a 48 kHz increment table. At the top notes, the phase wraps within a handful of ticks, so the random runs regularly carry the accumulator across the 2^32 boundary. All four quadrants of the sine table and both halves of the triangle fold are reached, as is every note's increment. Because the sawtooth output exposes the upper phase bits directly, a single tick from phase zero shows each increment. Over long random runs, any increment error builds up in the phase and shows in later samples.

// File: rtl/osc_pkg.sv
package osc_pkg;
  typedef enum logic [1:0] {
    WAVE_SINE   = 2'd0,
    WAVE_SQUARE = 2'd1,
    WAVE_SAW    = 2'd2,
    WAVE_TRI    = 2'd3
  } wave_e;

  function automatic longint round_real(input real r);
    if (r >= 0.0) return longint'($floor(r + 0.5));
    else          return -longint'($floor(-r + 0.5));
  endfunction
endpackage

// File: rtl/osc_incr_lut.sv
module osc_incr_lut #(
  parameter int NOTE_W    = 7,
  parameter int PHASE_W   = 32,
  parameter int SAMPLE_HZ = 48000
) (
  input  logic [NOTE_W-1:0]  note_i,
  output logic [PHASE_W-1:0] incr_o
);
  localparam int NUM_NOTES = 1 << NOTE_W;

  logic [PHASE_W-1:0] lut [NUM_NOTES];

  // ROM contents computed at elaboration
  initial begin
    for (int n = 0; n < NUM_NOTES; n++) begin
      real    hz;
      longint v;
      hz = 440.0 * $pow(2.0, (real'(n) - 69.0) / 12.0);
      v  = osc_pkg::round_real(hz * $pow(2.0, real'(PHASE_W)) / real'(SAMPLE_HZ));
      lut[n] = v[PHASE_W-1:0];
    end
  end

  assign incr_o = lut[note_i];
endmodule

// File: rtl/osc_phase_acc.sv
module osc_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               run_i,
  input  logic [PHASE_W-1:0] incr_i,
  output logic [PHASE_W-1:0] phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_o <= '0;
    else if (!run_i) phase_o <= '0;
    else if (tick_i) phase_o <= phase_o + incr_i;
  end
endmodule

// File: rtl/osc_sine_ram.sv
module osc_sine_ram #(
  parameter int ADDR_W   = 10,
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rd_en_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic signed [SAMPLE_W-1:0] data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam real AMP  = real'((1 << (SAMPLE_W - 1)) - 1);

  logic signed [SAMPLE_W-1:0] mem [DEPTH];

  initial begin
    for (int k = 0; k < DEPTH; k++) begin
      longint v;
      v = osc_pkg::round_real(AMP * $sin(2.0 * 3.14159265358979323846 * real'(k) / real'(DEPTH)));
      mem[k] = v[SAMPLE_W-1:0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rd_en_i) data_o <= mem[addr_i];
  end
endmodule

// File: rtl/osc_shaper.sv
module osc_shaper
  import osc_pkg::*;
#(
  parameter int PHASE_W  = 32,
  parameter int SAMPLE_W = 16
) (
  input  logic [PHASE_W-1:0]         phase_i,
  input  wave_e                      sel_i,
  input  logic signed [SAMPLE_W-1:0] sine_i,
  output logic signed [SAMPLE_W-1:0] sample_o
);
  localparam logic [SAMPLE_W-1:0] SIGN_FLIP = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] POS_FS    = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] NEG_FS    = ~POS_FS + 1'b1;

  logic [SAMPLE_W-1:0] saw, fold;

  assign saw  = phase_i[PHASE_W-1 -: SAMPLE_W] ^ SIGN_FLIP;
  assign fold = phase_i[PHASE_W-1] ? ~phase_i[PHASE_W-2 -: SAMPLE_W]
                                   :  phase_i[PHASE_W-2 -: SAMPLE_W];

  always_comb begin
    unique case (sel_i)
      WAVE_SINE:   sample_o = sine_i;
      WAVE_SQUARE: sample_o = phase_i[PHASE_W-1] ? NEG_FS : POS_FS;
      WAVE_SAW:    sample_o = saw;
      WAVE_TRI:    sample_o = fold ^ SIGN_FLIP;
      default:     sample_o = '0;
    endcase
  end
endmodule

// File: rtl/wavetable_osc.sv
module wavetable_osc
  import osc_pkg::*;
#(
  parameter int NOTE_W    = 7,
  parameter int PHASE_W   = 32,
  parameter int ADDR_W    = 10,
  parameter int SAMPLE_W  = 16,
  parameter int SAMPLE_HZ = 48000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic [NOTE_W-1:0]   note_i,
  input  logic                note_valid_i,
  input  logic [1:0]          wave_sel_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                valid_o
);
  logic [PHASE_W-1:0]         incr;
  logic [PHASE_W-1:0]         phase_q;
  logic [PHASE_W-1:0]         phase_s;
  logic signed [SAMPLE_W-1:0] sine_q;
  logic signed [SAMPLE_W-1:0] shaped;
  wave_e                      sel_s;
  logic                       take;
  logic                       vld_q;

  assign take = tick_i & note_valid_i;

  osc_incr_lut #(.NOTE_W(NOTE_W), .PHASE_W(PHASE_W), .SAMPLE_HZ(SAMPLE_HZ)) u_lut (
    .note_i (note_i),
    .incr_o (incr)
  );

  osc_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .run_i   (note_valid_i),
    .incr_i  (incr),
    .phase_o (phase_q)
  );

  osc_sine_ram #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) u_ram (
    .clk_i   (clk_i),
    .rd_en_i (take),
    .addr_i  (phase_q[PHASE_W-1 -: ADDR_W]),
    .data_o  (sine_q)
  );

  // snapshot of pre-update phase and select, aligned with RAM latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_s <= '0;
      sel_s   <= WAVE_SINE;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= take;
      if (take) begin
        phase_s <= phase_q;
        sel_s   <= wave_e'(wave_sel_i);
      end
    end
  end

  osc_shaper #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) u_shape (
    .phase_i  (phase_s),
    .sel_i    (sel_s),
    .sine_i   (sine_q),
    .sample_o (shaped)
  );

  assign valid_o  = vld_q;
  assign sample_o = vld_q ? shaped : '0;
endmodule

// File: rtl/wavetable_osc_chk.sv
module wavetable_osc_chk #(
  parameter int PHASE_W  = 32,
  parameter int SAMPLE_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tick_i,
  input logic                note_valid_i,
  input logic [1:0]          wave_sel_i,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic                valid_o,
  input logic [PHASE_W-1:0]  phase_q
);
  localparam logic [SAMPLE_W-1:0] POS_FS = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic [SAMPLE_W-1:0] NEG_FS = ~POS_FS + 1'b1;

  assert_strobe_after_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && note_valid_i) |=> valid_o);

  assert_no_spurious_strobe_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tick_i && note_valid_i) |=> !valid_o);

  assert_quiet_output_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> sample_o == '0);

  assert_phase_cleared_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !note_valid_i |=> phase_q == '0);

  assert_phase_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (note_valid_i && !tick_i) |=> $stable(phase_q));

  assert_square_levels_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && note_valid_i && wave_sel_i == 2'd1) |=> (sample_o == POS_FS || sample_o == NEG_FS));
endmodule

bind wavetable_osc wavetable_osc_chk #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tick_i       (tick_i),
  .note_valid_i (note_valid_i),
  .wave_sel_i   (wave_sel_i),
  .sample_o     (sample_o),
  .valid_o      (valid_o),
  .phase_q      (phase_q)
);

// File: tb/tb_wavetable_osc.sv
`timescale 1ns/1ps
module tb_wavetable_osc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [6:0]  note = '0;
  logic        nv = 1'b0;
  logic [1:0]  sel = '0;
  logic [15:0] sample;
  logic        valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] mphase = '0;

  always #10 clk = ~clk;

  wavetable_osc dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .note_i(note),
    .note_valid_i(nv), .wave_sel_i(sel), .sample_o(sample), .valid_o(valid)
  );

  function automatic longint rnd(input real r);
    if (r >= 0.0) return longint'($floor(r + 0.5));
    return -longint'($floor(-r + 0.5));
  endfunction

  function automatic logic [31:0] exp_incr(input int n);
    longint v;
    v = rnd(440.0 * $pow(2.0, (real'(n) - 69.0) / 12.0) * 4294967296.0 / 48000.0);
    return v[31:0];
  endfunction

  function automatic logic [15:0] exp_sample(input logic [31:0] ph, input logic [1:0] s);
    logic [15:0] t;
    longint v;
    case (s)
      2'd0: begin
        v = rnd(32767.0 * $sin(2.0 * 3.14159265358979323846 * real'(ph[31:22]) / 1024.0));
        return v[15:0];
      end
      2'd1: return ph[31] ? 16'h8001 : 16'h7FFF;
      2'd2: return ph[31:16] ^ 16'h8000;
      default: begin
        t = ph[31] ? ~ph[30:15] : ph[30:15];
        return t ^ 16'h8000;
      end
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one qualifying tick, then check the strobe cycle
  task automatic do_tick(input int n, input logic [1:0] s, input string req);
    @(negedge clk);
    tick = 1'b1; nv = 1'b1; note = n[6:0]; sel = s;
    @(negedge clk);
    tick = 1'b0;
    check({req, " valid"}, {31'd0, valid}, 32'd1);
    check(req, {16'd0, sample}, {16'd0, exp_sample(mphase, s)});
    mphase = mphase + exp_incr(n);
  endtask

  task automatic idle(input int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      check("R5 idle valid", {31'd0, valid}, 32'd0);
      check("R5 idle sample", {16'd0, sample}, 32'd0);
    end
  endtask

  task automatic note_off();
    @(negedge clk);
    nv = 1'b0; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check("R4 no strobe", {31'd0, valid}, 32'd0);
    check("R4 zero out", {16'd0, sample}, 32'd0);
    mphase = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240314));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, valid}, 32'd0);
    check("R1 reset sample", {16'd0, sample}, 32'd0);
    rst_n = 1'b1;
    idle(3);

    // R2: sawtooth after one tick from zero exposes increment top bits
    for (int n = 0; n < 128; n++) begin
      note_off();
      do_tick(n, 2'd2, "R8 saw at zero");
      do_tick(n, 2'd2, "R2 increment");
    end

    // R6..R9 directed shapes at phase 0
    note_off();
    do_tick(69, 2'd0, "R6 sine zero");
    do_tick(69, 2'd1, "R7 square");
    do_tick(69, 2'd3, "R9 triangle");
    do_tick(69, 2'd0, "R6 sine");

    // R10: note change mid-stream keeps phase
    do_tick(100, 2'd2, "R10 note change");
    do_tick(20, 2'd2, "R10 after change");
    idle(2);
    do_tick(20, 2'd3, "R3 held across idle");

    // random mix, wraps happen at high notes
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 3) note_off();
      else if (r < 15) idle(int'($urandom_range(1, 3)));
      else do_tick(int'($urandom_range(60, 127)), 2'($urandom_range(0, 3)), "R3 R6 R9 random");
    end

    note_off();
    idle(2);
    finish_run();
  end
endmodule